// File: doc/BRIEF.md
# Locked Slow-Domain Register Write Bridge

This block sits between a fast host write bus and a register bank that is clocked by a 32.768 kHz always-on oscillator. Bank writes pass only while a two-key lock is open. The lock opens when the right patterns are written to two key registers, first key A and then key B. The bridge carries one address/data pair at a time across the clock boundary, using a toggle/acknowledge handshake with two-flop synchronizers in each direction. A pending flag covers each transfer, and software polls that flag before it issues the next write.

The host-facing write port is a valid/ready stream. `h_wready` is held high: the bridge never applies back-pressure. A bank write that cannot be accepted is dropped rather than stalled. The host must watch the pending flag itself, because a bank write that arrives while a transfer is still in flight is discarded and recorded in a sticky error bit. A status word gives the host a synchronized copy of a slow-clock toggle, so software can see that the oscillator runs. A control bit selects a long or a short completion limit. A transfer that stays pending longer than the selected limit sets a sticky timeout bit.

Bank addresses are word-aligned byte addresses 0x00 to 0x50. Most bank bits have no reset value, so software writes the bank in ascending address order after power-up. The bridge's own registers sit above the bank: key A at 0x60, key B at 0x64, control at 0x68 and status at 0x6C.

Top module: `slow_wr_bridge`

## Requirements
- R1: After reset the bridge is locked. Status (0x6C) reads pending bit 0 = 0, overrun bit 2 = 0, timeout bit 3 = 0 and unlocked bit 4 = 0. Control (0x68) bit 0 (long mode) reads 1.
- R2: Writing 0x83E7_0B13 to key A (0x60) and then 0x95A4_F1E0 to key B (0x64) sets status bit 4. The same two patterns written in the reverse order leave the bridge locked.
- R3: Any key B write other than the correct pattern following a correct key A write clears status bit 4. This includes writing zero to relock. A wrong key A value also voids a preceding key A match.
- R4: While status bit 4 is 0, bank writes are ignored. Nothing is forwarded and the pending bit stays 0.
- R5: An accepted bank write sets the pending bit from the next host cycle. It reaches the slow side exactly once, as a one-slow-cycle `s_wr_valid` carrying the same address and data. The pending bit clears only after that write has landed.
- R6: A bank write that arrives while pending is 1 is dropped and sets sticky overrun bit 2. Writing 1 to status bit 2 clears it.
- R7: Status bit 1 follows a slow-domain flop that toggles on every slow clock edge, so it changes value while the oscillator runs.
- R8: A transfer pending for more than LONG_LIMIT host cycles (control bit 0 = 1) or SHORT_LIMIT host cycles (bit 0 = 0) sets sticky timeout bit 3. Writing 1 to bit 3 clears it.
- R9: Only word-aligned bank addresses from 0x00 to 0x50 are forwarded. Unaligned addresses and addresses above 0x50 that are not bridge registers have no effect.
- R10: `h_wready` is 1 whenever reset is released. No write is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_h | input | 1 | Host clock |
| rst_h_n | input | 1 | Host-domain asynchronous reset, active low |
| h_wvalid | input | 1 | Host write valid |
| h_wready | output | 1 | Host write ready, held high |
| h_waddr | input | 8 | Host write byte address |
| h_wdata | input | 32 | Host write data |
| h_raddr | input | 8 | Host read byte address |
| h_rdata | output | 32 | Host read data (control or status, else zero) |
| clk_s | input | 1 | 32.768 kHz slow clock |
| rst_s_n | input | 1 | Slow-domain asynchronous reset, active low |
| s_wr_valid | output | 1 | One-slow-cycle write strobe to the bank |
| s_wr_addr | output | 8 | Bank write byte address |
| s_wr_data | output | 32 | Bank write data |

## Verification
The bound checker checks several rules on every host cycle:
- a transfer starts only while unlocked;
- the held address and data stay frozen while a transfer is pending;
- a bank write during a pending transfer always raises the overrun bit, and a locked write never starts one;
- any key B write that is not the correct pattern leaves the bridge locked.

On the slow side, every strobe is checked to last exactly one cycle.

The scenarios show what no single-cycle property covers:
- each accepted write arrives once with the right address and data (by scoreboard);
- the key order matters;
- the slow-clock observation bit toggles;
- the round trip stays under the long limit and overruns the short one.

// File: rtl/slow_wr_pkg.sv
package slow_wr_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam logic [ADDR_W-1:0] BANK_TOP  = 8'h50;
  localparam logic [ADDR_W-1:0] KEYA_ADDR = 8'h60;
  localparam logic [ADDR_W-1:0] KEYB_ADDR = 8'h64;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h68;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h6C;
  localparam int ST_PEND = 0;
  localparam int ST_OBS  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_TMO  = 3;
  localparam int ST_UNLK = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_item_t;
endpackage

// File: rtl/slow_wr_keylock.sv
module slow_wr_keylock #(
  parameter int          DW     = 32,
  parameter logic [31:0] KEYA_P = 32'h83E7_0B13,
  parameter logic [31:0] KEYB_P = 32'h95A4_F1E0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_keya,
  input  logic          wr_keyb,
  input  logic [DW-1:0] wdata,
  output logic          unlocked
);
  logic keya_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keya_ok  <= 1'b0;
      unlocked <= 1'b0;
    end else begin
      if (wr_keya) keya_ok <= (wdata == KEYA_P[DW-1:0]);
      if (wr_keyb) begin
        keya_ok  <= 1'b0;
        unlocked <= keya_ok && (wdata == KEYB_P[DW-1:0]);
      end
    end
  end
endmodule

// File: rtl/slow_wr_xfer.sv
module slow_wr_xfer
  import slow_wr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_h,
  input  logic               rst_h_n,
  input  logic               launch,
  input  wr_item_t           item_in,
  output logic               pend,
  output wr_item_t           held,
  input  logic               clk_s,
  input  logic               rst_s_n,
  output logic               s_valid,
  output logic               s_beat
);
  logic                   req_tgl;
  logic                   ack_tgl;
  logic [SYNC_STAGES-1:0] req_sync;
  logic [SYNC_STAGES-1:0] ack_sync;
  logic                   req_prev;

  // host side: launch flips the request toggle and freezes the item
  always_ff @(posedge clk_h or negedge rst_h_n) begin
    if (!rst_h_n) begin
      req_tgl <= 1'b0;
      held    <= '0;
    end else if (launch) begin
      req_tgl <= ~req_tgl;
      held    <= item_in;
    end
  end

  // acknowledge synchronizer into the host domain
  always_ff @(posedge clk_h or negedge rst_h_n) begin
    if (!rst_h_n) ack_sync <= '0;
    else          ack_sync <= {ack_sync[SYNC_STAGES-2:0], ack_tgl};
  end

  assign pend = req_tgl ^ ack_sync[SYNC_STAGES-1];

  // slow side: request synchronizer, edge detect, acknowledge
  always_ff @(posedge clk_s or negedge rst_s_n) begin
    if (!rst_s_n) begin
      req_sync <= '0;
      req_prev <= 1'b0;
      ack_tgl  <= 1'b0;
      s_beat   <= 1'b0;
    end else begin
      req_sync <= {req_sync[SYNC_STAGES-2:0], req_tgl};
      req_prev <= req_sync[SYNC_STAGES-1];
      ack_tgl  <= req_sync[SYNC_STAGES-1];
      s_beat   <= ~s_beat;
    end
  end

  assign s_valid = req_sync[SYNC_STAGES-1] ^ req_prev;
endmodule

// File: rtl/slow_wr_timer.sv
module slow_wr_timer #(
  parameter int LONG_LIMIT  = 4000,
  parameter int SHORT_LIMIT = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic long_mode,
  input  logic clr,
  output logic timeout
);
  localparam int MAXL = (LONG_LIMIT > SHORT_LIMIT) ? LONG_LIMIT : SHORT_LIMIT;
  localparam int CW   = $clog2(MAXL + 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = long_mode ? CW'(LONG_LIMIT) : CW'(SHORT_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      if (!pend)         cnt <= '0;
      else if (cnt <= lim) cnt <= cnt + 1'b1;
      if (pend && cnt == lim) timeout <= 1'b1;
      else if (clr)           timeout <= 1'b0;
    end
  end
endmodule

// File: rtl/slow_wr_bridge.sv
module slow_wr_bridge
  import slow_wr_pkg::*;
#(
  parameter int          LONG_LIMIT  = 4000,
  parameter int          SHORT_LIMIT = 1500,
  parameter logic [31:0] KEYA_P      = 32'h83E7_0B13,
  parameter logic [31:0] KEYB_P      = 32'h95A4_F1E0
) (
  input  logic              clk_h,
  input  logic              rst_h_n,
  input  logic              h_wvalid,
  output logic              h_wready,
  input  logic [ADDR_W-1:0] h_waddr,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [ADDR_W-1:0] h_raddr,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              clk_s,
  input  logic              rst_s_n,
  output logic              s_wr_valid,
  output logic [ADDR_W-1:0] s_wr_addr,
  output logic [DATA_W-1:0] s_wr_data
);
  logic     bank_hit, wr_bank, launch, ovr_set;
  logic     wr_keya, wr_keyb, wr_ctrl, wr_stat;
  logic     unlocked, pend, long_mode, ovr_err, tmo_err, s_beat;
  logic [1:0] obs_sync;
  wr_item_t held, item_in;

  assign h_wready = rst_h_n;
  assign bank_hit = (h_waddr[1:0] == 2'b00) && (h_waddr <= BANK_TOP);
  assign wr_bank  = h_wvalid && bank_hit;
  assign launch   = wr_bank && unlocked && !pend;
  assign ovr_set  = wr_bank && unlocked && pend;
  assign wr_keya  = h_wvalid && (h_waddr == KEYA_ADDR);
  assign wr_keyb  = h_wvalid && (h_waddr == KEYB_ADDR);
  assign wr_ctrl  = h_wvalid && (h_waddr == CTRL_ADDR);
  assign wr_stat  = h_wvalid && (h_waddr == STAT_ADDR);
  assign item_in  = '{addr: h_waddr, data: h_wdata};

  slow_wr_keylock #(.DW(DATA_W), .KEYA_P(KEYA_P), .KEYB_P(KEYB_P)) u_key (
    .clk(clk_h), .rst_n(rst_h_n), .wr_keya(wr_keya), .wr_keyb(wr_keyb),
    .wdata(h_wdata), .unlocked(unlocked)
  );

  slow_wr_xfer #(.SYNC_STAGES(2)) u_xfer (
    .clk_h(clk_h), .rst_h_n(rst_h_n), .launch(launch), .item_in(item_in),
    .pend(pend), .held(held), .clk_s(clk_s), .rst_s_n(rst_s_n),
    .s_valid(s_wr_valid), .s_beat(s_beat)
  );

  slow_wr_timer #(.LONG_LIMIT(LONG_LIMIT), .SHORT_LIMIT(SHORT_LIMIT)) u_tmr (
    .clk(clk_h), .rst_n(rst_h_n), .pend(pend), .long_mode(long_mode),
    .clr(wr_stat && h_wdata[ST_TMO]), .timeout(tmo_err)
  );

  assign s_wr_addr = held.addr;
  assign s_wr_data = held.data;

  always_ff @(posedge clk_h or negedge rst_h_n) begin
    if (!rst_h_n) begin
      long_mode <= 1'b1;
      ovr_err   <= 1'b0;
      obs_sync  <= '0;
    end else begin
      obs_sync <= {obs_sync[0], s_beat};
      if (wr_ctrl) long_mode <= h_wdata[0];
      if (ovr_set)                         ovr_err <= 1'b1;
      else if (wr_stat && h_wdata[ST_OVR]) ovr_err <= 1'b0;
    end
  end

  always_comb begin
    h_rdata = '0;
    if (h_raddr == CTRL_ADDR) h_rdata[0] = long_mode;
    else if (h_raddr == STAT_ADDR) begin
      h_rdata[ST_PEND] = pend;
      h_rdata[ST_OBS]  = obs_sync[1];
      h_rdata[ST_OVR]  = ovr_err;
      h_rdata[ST_TMO]  = tmo_err;
      h_rdata[ST_UNLK] = unlocked;
    end
  end
endmodule

// File: rtl/slow_wr_bridge_chk.sv
module slow_wr_bridge_chk
  import slow_wr_pkg::*;
#(
  parameter logic [31:0] KEYB_P = 32'h95A4_F1E0
) (
  input logic              clk_h,
  input logic              rst_h_n,
  input logic              clk_s,
  input logic              rst_s_n,
  input logic              h_wvalid,
  input logic [ADDR_W-1:0] h_waddr,
  input logic [DATA_W-1:0] h_wdata,
  input logic              pend,
  input logic              unlocked,
  input logic              ovr_err,
  input logic              s_wr_valid,
  input logic [ADDR_W-1:0] s_wr_addr,
  input logic [DATA_W-1:0] s_wr_data
);
  logic bank_w;
  assign bank_w = h_wvalid && (h_waddr[1:0] == 2'b00) && (h_waddr <= BANK_TOP);

  assert_start_unlocked_R4: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    $rose(pend) |-> $past(unlocked));

  assert_locked_no_start_R4: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    (bank_w && !unlocked && !pend) |=> !pend);

  assert_hold_stable_R5: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    (pend && $past(pend)) |-> ($stable(s_wr_addr) && $stable(s_wr_data)));

  assert_overrun_flag_R6: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    (bank_w && unlocked && pend) |=> ovr_err);

  assert_keyb_relock_R3: assert property (@(posedge clk_h) disable iff (!rst_h_n)
    (h_wvalid && h_waddr == KEYB_ADDR && h_wdata != KEYB_P) |=> !unlocked);

  assert_strobe_single_R5: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    s_wr_valid |=> !s_wr_valid);
endmodule

bind slow_wr_bridge slow_wr_bridge_chk #(.KEYB_P(KEYB_P)) u_chk (
  .clk_h(clk_h), .rst_h_n(rst_h_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
  .h_wvalid(h_wvalid), .h_waddr(h_waddr), .h_wdata(h_wdata),
  .pend(pend), .unlocked(unlocked), .ovr_err(ovr_err),
  .s_wr_valid(s_wr_valid), .s_wr_addr(s_wr_addr), .s_wr_data(s_wr_data)
);

// File: tb/tb_slow_wr_bridge.sv
module tb_slow_wr_bridge;
  import slow_wr_pkg::*;

  localparam int CLK_PERIOD  = 10;
  localparam int SLOW_PERIOD = CLK_PERIOD * 1000;
  localparam int LONG_LIM    = 4000;
  localparam int SHORT_LIM   = 1500;
  localparam logic [31:0] KA = 32'h83E7_0B13;
  localparam logic [31:0] KB = 32'h95A4_F1E0;

  logic clk_h = 0, clk_s = 0, rst_h_n = 0, rst_s_n = 0;
  logic h_wvalid = 0, h_wready, s_wr_valid;
  logic [7:0]  h_waddr = 0, h_raddr = 0, s_wr_addr;
  logic [31:0] h_wdata = 0, h_rdata, s_wr_data;

  int checks = 0, fails = 0;
  wr_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk_h = ~clk_h;
  always #(SLOW_PERIOD/2) clk_s = ~clk_s;

  slow_wr_bridge #(.LONG_LIMIT(LONG_LIM), .SHORT_LIMIT(SHORT_LIM)) dut (
    .clk_h(clk_h), .rst_h_n(rst_h_n), .h_wvalid(h_wvalid), .h_wready(h_wready),
    .h_waddr(h_waddr), .h_wdata(h_wdata), .h_raddr(h_raddr), .h_rdata(h_rdata),
    .clk_s(clk_s), .rst_s_n(rst_s_n), .s_wr_valid(s_wr_valid),
    .s_wr_addr(s_wr_addr), .s_wr_data(s_wr_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bank writes as they appear on the slow side
  always @(negedge clk_s) begin
    if (rst_s_n && s_wr_valid) begin
      if (exp_q.size() == 0)
        chk(0, "R4/R9 unexpected forward", {s_wr_addr, s_wr_data}, 40'h0);
      else begin
        wr_item_t e;
        e = exp_q.pop_front();
        chk({s_wr_addr, s_wr_data} == {e.addr, e.data}, "R5 forwarded item",
            {s_wr_addr, s_wr_data}, {e.addr, e.data});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit expect_fwd);
    @(negedge clk_h);
    h_wvalid = 1; h_waddr = a; h_wdata = d;
    if (expect_fwd) exp_q.push_back('{addr: a, data: d});
    @(negedge clk_h);
    h_wvalid = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    h_raddr = a;
    #1 v = h_rdata;
  endtask

  task automatic wait_idle(input int limit, input bit check_lim);
    logic [31:0] s;
    int n = 0;
    rd(STAT_ADDR, s);
    while (s[ST_PEND]) begin
      @(negedge clk_h); n++;
      rd(STAT_ADDR, s);
    end
    if (check_lim) chk(n <= limit, "R8 pending duration within long limit", 40'(n), 40'(limit));
  endtask

  initial begin
    logic [31:0] v;
    bit seen0, seen1;
    repeat (5) @(negedge clk_h);
    rst_h_n = 1; rst_s_n = 1;
    @(negedge clk_h);
    // R1 reset state
    rd(STAT_ADDR, v);
    chk((v & 32'h1D) == 0, "R1 status after reset", 40'(v & 32'h1D), 40'h0);
    rd(CTRL_ADDR, v);
    chk(v == 1, "R1 long mode after reset", 40'(v), 40'h1);
    chk(h_wready == 1, "R10 ready high", 40'(h_wready), 40'h1);

    // R4 locked write ignored
    wr(8'h00, 32'hDEAD_0001, 0);
    rd(STAT_ADDR, v);
    chk(v[ST_PEND] == 0, "R4 no pending when locked", 40'(v[ST_PEND]), 40'h0);
    repeat (3500) @(negedge clk_h);

    // R2 wrong order keeps lock closed
    wr(KEYB_ADDR, KB, 0); wr(KEYA_ADDR, KA, 0);
    rd(STAT_ADDR, v);
    chk(v[ST_UNLK] == 0, "R2 reverse order stays locked", 40'(v[ST_UNLK]), 40'h0);
    // R2 correct order
    wr(KEYA_ADDR, KA, 0); wr(KEYB_ADDR, KB, 0);
    rd(STAT_ADDR, v);
    chk(v[ST_UNLK] == 1, "R2 unlocked", 40'(v[ST_UNLK]), 40'h1);

    // R5 ascending initialization, including top address 0x50
    for (int i = 0; i < 5; i++) begin
      wr(8'(i * 20), 32'hA5A5_0000 + 32'(i), 1);
      chk(h_wready == 1, "R10 ready during traffic", 40'(h_wready), 40'h1);
      rd(STAT_ADDR, v);
      chk(v[ST_PEND] == 1, "R5 pending set after accept", 40'(v[ST_PEND]), 40'h1);
      wait_idle(LONG_LIM, 1);
    end

    // R9 out-of-range and unaligned addresses ignored
    wr(8'h54, 32'h1111_1111, 0);
    rd(STAT_ADDR, v);
    chk(v[ST_PEND] == 0, "R9 addr 0x54 ignored", 40'(v[ST_PEND]), 40'h0);
    wr(8'h06, 32'h2222_2222, 0);
    rd(STAT_ADDR, v);
    chk(v[ST_PEND] == 0, "R9 unaligned ignored", 40'(v[ST_PEND]), 40'h0);

    // R6 overlap dropped and flagged
    wr(8'h04, 32'h0BAD_C0DE, 1);
    wr(8'h08, 32'hFFFF_0000, 0);
    rd(STAT_ADDR, v);
    chk(v[ST_OVR] == 1, "R6 overrun flagged", 40'(v[ST_OVR]), 40'h1);
    wait_idle(LONG_LIM, 1);
    wr(STAT_ADDR, 32'h4, 0);
    rd(STAT_ADDR, v);
    chk(v[ST_OVR] == 0, "R6 overrun cleared", 40'(v[ST_OVR]), 40'h0);

    // R7 slow-clock observation toggles
    seen0 = 0; seen1 = 0;
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk_h);
      rd(STAT_ADDR, v);
      if (v[ST_OBS]) seen1 = 1; else seen0 = 1;
    end
    chk(seen0 && seen1, "R7 clock observation toggles", {38'h0, seen1, seen0}, 40'h3);

    // R8 short mode times out, long mode does not
    wr(CTRL_ADDR, 32'h0, 0);
    wr(8'h10, 32'h5555_AAAA, 1);
    wait_idle(SHORT_LIM, 0);
    rd(STAT_ADDR, v);
    chk(v[ST_TMO] == 1, "R8 short limit exceeded", 40'(v[ST_TMO]), 40'h1);
    wr(STAT_ADDR, 32'h8, 0);
    wr(CTRL_ADDR, 32'h1, 0);
    wr(8'h14, 32'h1234_5678, 1);
    wait_idle(LONG_LIM, 1);
    rd(STAT_ADDR, v);
    chk(v[ST_TMO] == 0, "R8 long limit met", 40'(v[ST_TMO]), 40'h0);

    // R3 relock by zero, then bank write ignored
    wr(KEYB_ADDR, 32'h0, 0);
    rd(STAT_ADDR, v);
    chk(v[ST_UNLK] == 0, "R3 relock by zero", 40'(v[ST_UNLK]), 40'h0);
    wr(8'h20, 32'h7777_7777, 0);
    rd(STAT_ADDR, v);
    chk(v[ST_PEND] == 0, "R4 write after relock ignored", 40'(v[ST_PEND]), 40'h0);
    // R3 wrong key A voids match
    wr(KEYA_ADDR, KA, 0); wr(KEYA_ADDR, 32'h1, 0); wr(KEYB_ADDR, KB, 0);
    rd(STAT_ADDR, v);
    chk(v[ST_UNLK] == 0, "R3 wrong key A voids", 40'(v[ST_UNLK]), 40'h0);

    repeat (4000) @(negedge clk_h);
    chk(exp_q.size() == 0, "R5 every accepted write landed", 40'(exp_q.size()), 40'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule